// File: doc/BRIEF.md
# Serial Amplifier Control Register

This block receives 8-bit command words over a three-wire serial link (data, serial clock, active-high enable) and turns the last accepted word into control lines for an audio amplifier. It has one speaker path and left and right headset paths. The serial inputs are brought into the system clock domain by synchronisers, and all edge detection happens there. The system clock must run at least four times as fast as the serial clock, which tops out at 10 MHz.

While the enable is high, each rising edge of the serial clock shifts one data bit into the receiver, least significant bit first. Clock edges that arrive after the eighth bit are ignored. When the enable falls, a complete frame is copied into the holding register. A frame with fewer than 8 bits leaves the held settings alone and produces a one-cycle error pulse instead.

The low three bits of the held word select the output-routing mode. The upper five bits are a gain code that goes to both gain stages unchanged. For stage 2, code 0 means -34.5 dB and code 31 means +12 dB. For stage 1, code 0 means -40.5 dB and code 31 means +6 dB. Each code step is 1.5 dB on both stages.

When a frame takes the amplifier out of shutdown, every path output stays low for a programmable number of system clock cycles. The ready line then rises.

Top module: `amp_ctl_rx`

## Requirements
- R1: After reset, every path output is 0, both gain codes are 0, `amp_ready` is 0 and `frame_err` is 0.
- R2: Bits are taken LSB first. Word bits 2..0 form the mode and bits 7..3 form the gain code, with bit 3 as its LSB. The gain code appears on both `gain1_code` and `gain2_code`. A complete frame shows on the outputs 4 system clock cycles after the enable's fall reaches the input.
- R3: In a frame of more than 8 bits, only the first 8 are kept.
- R4: A frame of fewer than 8 bits leaves every output unchanged and raises `frame_err` for exactly one cycle, 3 cycles after the enable falls.
- R5: Serial clock edges while the enable is low shift nothing and commit nothing.
- R6: `spk_en` equals mode bit 0 (the handsfree input at a fixed +12 dB) whenever `amp_ready` is 1.
- R7: `spk_mute` is 1 when mode bit 0 is 0 and mode bit 1 or bit 2 is 1, with `amp_ready` at 1. `spk_en` and `spk_mute` are never both 1.
- R8: `hs_l_en` and `hs_r_en` both equal (bit 1 OR bit 2). `hs_phone_sel` equals bit 1, which routes the phone input through stage 1. `hs_line_sel` equals bit 2, which routes the stereo inputs through stage 2. When both are set, the two sources are mixed.
- R9: Mode 0 turns every path output off and clears `amp_ready` in the same cycle the word is committed.
- R10: When a frame takes the mode from 0 to non-zero, `amp_ready` rises `startup_cycles`+1 cycles after the commit. While `amp_ready` is 0, every path output is 0.
- R11: A commit from one non-zero mode to another non-zero mode leaves `amp_ready` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_en | input | 1 | Frame enable, active high; its fall commits the frame |
| ser_dat | input | 1 | Serial data, LSB first |
| startup_cycles | input | CNT_W | Startup delay in system cycles, sampled at commit |
| spk_en | output | 1 | Speaker amplifier driving |
| spk_mute | output | 1 | Speaker amplifier muted |
| hs_l_en | output | 1 | Left headset amplifier driving |
| hs_r_en | output | 1 | Right headset amplifier driving |
| hs_phone_sel | output | 1 | Phone input routed to the headset via stage 1 |
| hs_line_sel | output | 1 | Stereo inputs routed to the headset via stage 2 |
| gain1_code | output | GAIN_W | Gain code for stage 1 |
| gain2_code | output | GAIN_W | Gain code for stage 2 |
| amp_ready | output | 1 | Startup complete, outputs released |
| frame_err | output | 1 | One-cycle pulse for a short frame |

## Verification
Count cycles from the first system clock edge that sees the enable low. `frame_err` is valid after edge 3, the held settings and the decoded path outputs after edge 4, and `amp_ready` after edge 4 plus `startup_cycles`. The bench drives inputs on falling clock edges and counts exactly those rising edges before each falling-edge sample. This lets it check the ready line at the last cycle it must still be low and again at the first cycle it must be high. Every frame waits for startup to finish before the next one starts, so the expected ready state is always known.

// File: rtl/acr_pkg.sv
package acr_pkg;

   typedef struct packed {
      logic spk_en;
      logic spk_mute;
      logic hs_l_en;
      logic hs_r_en;
      logic phone_sel;
      logic line_sel;
   } route_t;

   // Mode bit 0: speaker on; bit 1: phone source to headset; bit 2: stereo source.
   function automatic route_t decode_route(input logic [2:0] m, input logic rdy);
      route_t r;
      r.spk_en    = rdy & m[0];
      r.spk_mute  = rdy & ~m[0] & (m[1] | m[2]);
      r.hs_l_en   = rdy & (m[1] | m[2]);
      r.hs_r_en   = rdy & (m[1] | m[2]);
      r.phone_sel = rdy & m[1];
      r.line_sel  = rdy & m[2];
      return r;
   endfunction

endpackage

// File: rtl/acr_sync.sv
module acr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/acr_shift.sv
module acr_shift #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_lvl,
   input  logic               en_lvl,
   input  logic               dat_lvl,
   output logic [FRAME_W-1:0] word,
   output logic               commit,
   output logic               err
);
   localparam int CW = $clog2(FRAME_W + 1);
   localparam int IW = $clog2(FRAME_W);

   logic          clk_d, en_d;
   logic [CW-1:0] cnt;
   logic          rise, fall, full;

   assign rise = clk_lvl & ~clk_d;
   assign fall = ~en_lvl & en_d;
   assign full = (cnt == CW'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d  <= 1'b0;
         en_d   <= 1'b0;
         cnt    <= '0;
         word   <= '0;
         commit <= 1'b0;
         err    <= 1'b0;
      end else begin
         clk_d  <= clk_lvl;
         en_d   <= en_lvl;
         commit <= fall & full;
         err    <= fall & ~full;
         if (!en_lvl) begin
            cnt <= '0;
         end else if (rise && !full) begin
            word[cnt[IW-1:0]] <= dat_lvl;
            cnt               <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/acr_startup.sv
module acr_startup #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             new_off,
   input  logic             old_off,
   input  logic [CNT_W-1:0] load,
   output logic             ready
);
   logic [CNT_W-1:0] cnt;
   logic             counting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         counting <= 1'b0;
         ready    <= 1'b0;
      end else if (commit && new_off) begin
         cnt      <= '0;
         counting <= 1'b0;
         ready    <= 1'b0;
      end else if (commit && old_off) begin
         cnt      <= load;
         counting <= 1'b1;
         ready    <= 1'b0;
      end else if (counting) begin
         if (cnt == '0) begin
            ready    <= 1'b1;
            counting <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/amp_ctl_rx.sv
module amp_ctl_rx #(
   parameter int GAIN_W      = 5,
   parameter int MODE_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_en,
   input  logic              ser_dat,
   input  logic [CNT_W-1:0]  startup_cycles,
   output logic              spk_en,
   output logic              spk_mute,
   output logic              hs_l_en,
   output logic              hs_r_en,
   output logic              hs_phone_sel,
   output logic              hs_line_sel,
   output logic [GAIN_W-1:0] gain1_code,
   output logic [GAIN_W-1:0] gain2_code,
   output logic              amp_ready,
   output logic              frame_err
);
   import acr_pkg::*;

   localparam int FRAME_W = MODE_W + GAIN_W;

   if (MODE_W != 3) begin : g_bad_mode
      $error("MODE_W must be 3: the routing decode uses three mode bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || GAIN_W < 1) begin : g_bad_width
      $error("CNT_W and GAIN_W must be positive");
   end

   logic [2:0]         lvl;
   logic [FRAME_W-1:0] word;
   logic [FRAME_W-1:0] held;
   logic               commit;
   route_t             route;

   acr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_en, ser_clk, ser_dat}), .q(lvl)
   );

   acr_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clk_lvl(lvl[1]), .en_lvl(lvl[2]), .dat_lvl(lvl[0]),
      .word(word), .commit(commit), .err(frame_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held <= '0;
      else if (commit) held <= word;
   end

   acr_startup #(.CNT_W(CNT_W)) u_start (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .new_off(word[MODE_W-1:0] == '0),
      .old_off(held[MODE_W-1:0] == '0),
      .load(startup_cycles), .ready(amp_ready)
   );

   assign route        = decode_route(held[MODE_W-1:0], amp_ready);
   assign spk_en       = route.spk_en;
   assign spk_mute     = route.spk_mute;
   assign hs_l_en      = route.hs_l_en;
   assign hs_r_en      = route.hs_r_en;
   assign hs_phone_sel = route.phone_sel;
   assign hs_line_sel  = route.line_sel;
   assign gain1_code   = held[FRAME_W-1:MODE_W];
   assign gain2_code   = held[FRAME_W-1:MODE_W];
endmodule

// File: rtl/amp_ctl_rx_chk.sv
module amp_ctl_rx_chk #(
   parameter int FRAME_W = 8,
   parameter int MODE_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               commit,
   input logic               err,
   input logic [FRAME_W-1:0] word,
   input logic [FRAME_W-1:0] held,
   input logic               ready,
   input logic               spk_en,
   input logic               spk_mute,
   input logic               hs_l_en,
   input logic               hs_r_en,
   input logic               phone_sel,
   input logic               line_sel
);
   a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   a_r4_err_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && commit));

   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(held));

   a_r9_off_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (held[MODE_W-1:0] == '0) |-> !ready);

   a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !(spk_en | spk_mute | hs_l_en | hs_r_en | phone_sel | line_sel));

   a_r11_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !(commit && word[MODE_W-1:0] == '0)) |=> ready);

   a_r7_mute_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(spk_en && spk_mute));

   a_r8_pair: assert property (@(posedge clk) disable iff (!rst_n)
      hs_l_en == hs_r_en);
endmodule

bind amp_ctl_rx amp_ctl_rx_chk #(.FRAME_W(FRAME_W), .MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .err(frame_err),
   .word(word), .held(held), .ready(amp_ready),
   .spk_en(spk_en), .spk_mute(spk_mute), .hs_l_en(hs_l_en), .hs_r_en(hs_r_en),
   .phone_sel(hs_phone_sel), .line_sel(hs_line_sel)
);

// File: tb/amp_ctl_rx_tb.sv
module amp_ctl_rx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_en = 1'b0, ser_dat = 1'b0;
   logic [15:0] startup_cycles = '0;
   logic        spk_en, spk_mute, hs_l_en, hs_r_en, hs_phone_sel, hs_line_sel;
   logic [4:0]  gain1_code, gain2_code;
   logic        amp_ready, frame_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [2:0] cur_m = '0;
   logic [4:0] cur_g = '0;
   logic       cur_rdy = 1'b0;

   always #10 clk = ~clk;

   amp_ctl_rx u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en), .ser_dat(ser_dat),
      .startup_cycles(startup_cycles), .spk_en(spk_en), .spk_mute(spk_mute),
      .hs_l_en(hs_l_en), .hs_r_en(hs_r_en), .hs_phone_sel(hs_phone_sel),
      .hs_line_sel(hs_line_sel), .gain1_code(gain1_code), .gain2_code(gain2_code),
      .amp_ready(amp_ready), .frame_err(frame_err)
   );

   function automatic logic [16:0] expect_vec(input logic [2:0] m, input logic [4:0] g,
                                               input logic r);
      logic hs;
      hs = m[1] | m[2];
      return {r & m[0], r & ~m[0] & hs, r & hs, r & hs, r & m[1], r & m[2], r, g, g};
   endfunction

   function automatic logic [16:0] obs_vec();
      return {spk_en, spk_mute, hs_l_en, hs_r_en, hs_phone_sel, hs_line_sel,
              amp_ready, gain1_code, gain2_code};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] bits, input int n);
      @(negedge clk);
      ser_en = 1'b1;
      cyc(4);
      for (int i = 0; i < n; i++) begin
         ser_dat = bits[i];
         cyc(4);
         ser_clk = 1'b1;
         cyc(4);
         ser_clk = 1'b0;
      end
      cyc(4);
      ser_en = 1'b0;
   endtask

   // Sends a frame and checks every result at its due cycle.
   task automatic frame(input string req, input logic [15:0] bits, input int n,
                        input logic [15:0] dly);
      logic       valid, leaving, rdy_exp;
      logic [2:0] nm;
      startup_cycles = dly;
      send(bits, n);
      valid = (n >= 8);
      nm    = bits[2:0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({req, "/R4 err pulse"}, 32'(frame_err), 32'(!valid));
      @(negedge clk);
      chk({req, "/R4 err width"}, 32'(frame_err), 32'd0);
      leaving = 1'b0;
      rdy_exp = cur_rdy;
      if (valid) begin
         leaving = (cur_m == 3'd0) && (nm != 3'd0);
         rdy_exp = (nm == 3'd0 || leaving) ? 1'b0 : cur_rdy;
         cur_m   = nm;
         cur_g   = bits[7:3];
      end
      chk({req, " commit"}, 32'(obs_vec()), 32'(expect_vec(cur_m, cur_g, rdy_exp)));
      cur_rdy = rdy_exp;
      if (leaving) begin
         repeat (int'(dly)) @(negedge clk);
         chk({req, "/R10 still low"}, 32'(obs_vec()), 32'(expect_vec(cur_m, cur_g, 1'b0)));
         @(negedge clk);
         chk({req, "/R10 released"}, 32'(obs_vec()), 32'(expect_vec(cur_m, cur_g, 1'b1)));
         cur_rdy = 1'b1;
      end
      cyc(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 reset outputs", 32'(obs_vec()), 32'(expect_vec(3'd0, 5'd0, 1'b0)));
      chk("R1 reset err", 32'(frame_err), 32'd0);

      frame("R2 lsb first", 16'h00A9, 8, 16'd5);   // mode 1, gain 21
      frame("R6 speaker", 16'h00F9, 8, 16'd0);
      frame("R11 keep ready", 16'h00FB, 8, 16'd9);
      frame("R7 mute phone", 16'h0052, 8, 16'd0);
      frame("R8 line", 16'h0004, 8, 16'd0);
      frame("R8 mix", 16'h0066, 8, 16'd0);
      frame("R6 spk+line", 16'h0085, 8, 16'd0);
      frame("R9 shutdown", 16'h0078, 8, 16'd0);
      frame("R10 zero delay", 16'h0017, 8, 16'd0);
      frame("R9 shutdown2", 16'h0000, 8, 16'd0);
      frame("R10 long delay", 16'h0033, 8, 16'd40);
      frame("R3 extra bits", 16'h0726, 11, 16'd0);
      frame("R4 short", 16'h001F, 5, 16'd0);
      frame("R4 one bit", 16'h0001, 1, 16'd0);

      // R5: clock pulses with the enable low do nothing
      for (int i = 0; i < 6; i++) begin
         ser_dat = i[0];
         cyc(4); ser_clk = 1'b1; cyc(4); ser_clk = 1'b0;
      end
      cyc(6);
      chk("R5 idle clocks", 32'(obs_vec()), 32'(expect_vec(cur_m, cur_g, cur_rdy)));
      chk("R5 no err", 32'(frame_err), 32'd0);
      frame("R5 next frame", 16'h00C5, 8, 16'd0);

      for (int k = 0; k < 60; k++) begin
         logic [15:0] b;
         int          n;
         b = 16'($urandom);
         n = 8 + int'($urandom % 3);
         if ($urandom % 6 == 0) n = 1 + int'($urandom % 7);
         frame("R8 random", b, n, 16'($urandom % 16));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule